// File: doc/BRIEF.md
# Integer Execution Unit with Signed Overflow Detection

This block is the integer datapath of a load/store RISC core. It is purely combinational. It takes a first source operand and a second source operand. The second source can be replaced by a 16-bit immediate that is widened by zero or sign extension. A 4-bit operation code selects what the unit does. The unit produces a 32-bit result and a single overflow flag in the same cycle.

The operations are add and subtract, each in a trapping form and a non-trapping form. It also performs the four bitwise functions, left and right shifts, and placement of an immediate into the upper half of the word. A shift takes its distance either from a constant field or from the low bits of the second operand. The unit only reports overflow. It always delivers the wrapped result, and the surrounding core decides whether to cancel the write-back or raise an exception.

Top module: `risc_int_alu`

## Requirements
- R1: Code 0 (ADD) and code 1 (ADDU) yield the first operand plus the second, modulo 2^32. Code 2 (SUB) and code 3 (SUBU) yield the first operand minus the second, modulo 2^32.
- R2: For codes 0 and 2, `ovf_o` is 1 exactly when the true two's-complement result lies outside the signed 32-bit range. Whenever `ovf_o` is 1, bit 31 of the result differs from bit 31 of the first operand.
- R3: Codes 1 (ADDU) and 3 (SUBU) never raise `ovf_o`, whatever the operands are.
- R4: Codes 4, 5, 6 and 7 yield bitwise AND, OR, XOR and NOR of the two operands, with `ovf_o` = 0.
- R5: Codes 8 (SLL), 9 (SRL) and 10 (SRA) shift the first operand by `shamt_i`. Left and logical right shifts fill with zeros, and the arithmetic right shift fills with bit 31. `ovf_o` is 0 for all of them.
- R6: Codes 11, 12 and 13 perform the same three shifts in the same order, but the distance is bits 4:0 of the second operand. Bits 31:5 of that operand have no effect, and neither does `shamt_i`.
- R7: When `use_imm_i` = 1, `b_i` is ignored and the second operand is `imm_i`. It is sign-extended when `sext_i` = 1 and zero-extended when `sext_i` = 0. This applies to every operation that reads the second operand, including the overflow check.
- R8: Code 14 (LUI) yields `imm_i` in bits 31:16 and zeros in bits 15:0, with `ovf_o` = 0. The operand inputs have no effect.
- R9: When overflow is flagged, the result is still the wrapped 32-bit sum or difference.
- R10: Code 15 is reserved and yields a result of 0 with `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0 to 15, as listed in the requirements) |
| a_i | input | 32 | First source operand; also the data that is shifted |
| b_i | input | 32 | Second source operand from the register file |
| imm_i | input | 16 | Immediate field of the instruction |
| use_imm_i | input | 1 | 1 selects the extended immediate as the second operand |
| sext_i | input | 1 | Extension mode: 1 sign-extends the immediate, 0 zero-extends it |
| shamt_i | input | 5 | Constant shift distance for codes 8 to 10 |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow flag for codes 0 and 2 |

## Verification
The bound checker watches, on every input change, that overflow appears only for the two trapping codes, and that a flagged result has flipped its sign against the first operand. It also watches the upper-half placement done by LUI, the fill bit of the right shifts, and the zero output for the reserved code. Exact arithmetic values can only be shown by the bench's scenarios, which compare against a reference model. The same holds for the extension chosen for an immediate, for the masking of a register shift distance to five bits, and for the extreme-operand overflow corners.

// File: rtl/rialu_pkg.sv
// Package: shared operation codes, shift kinds and the decoded control word
// for the integer execution unit. Assumes a 4-bit operation code.
package rialu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10,
        OP_SLLV = 4'd11,
        OP_SRLV = 4'd12,
        OP_SRAV = 4'd13,
        OP_LUI  = 4'd14,
        OP_RSVD = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT = 2'd0,
        SH_RLOG = 2'd1,
        SH_RARI = 2'd2
    } shift_kind_e;

    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2,
        LF_NOR = 2'd3
    } logic_fn_e;

    typedef struct packed {
        logic        is_arith;
        logic        is_sub;
        logic        is_signed;
        logic        is_logic;
        logic        is_shift;
        logic        shift_var;
        shift_kind_e sh_kind;
        logic_fn_e   log_fn;
        logic        is_lui;
    } alu_ctrl_t;

    // Translate an operation code into the control word; reserved code yields all-zero
    function automatic alu_ctrl_t decode_op(logic [3:0] op);
        alu_ctrl_t c;
        c = '0;
        case (op)
            OP_ADD:  begin c.is_arith = 1'b1; c.is_signed = 1'b1; end
            OP_ADDU: begin c.is_arith = 1'b1; end
            OP_SUB:  begin c.is_arith = 1'b1; c.is_sub = 1'b1; c.is_signed = 1'b1; end
            OP_SUBU: begin c.is_arith = 1'b1; c.is_sub = 1'b1; end
            OP_AND:  begin c.is_logic = 1'b1; c.log_fn = LF_AND; end
            OP_OR:   begin c.is_logic = 1'b1; c.log_fn = LF_OR;  end
            OP_XOR:  begin c.is_logic = 1'b1; c.log_fn = LF_XOR; end
            OP_NOR:  begin c.is_logic = 1'b1; c.log_fn = LF_NOR; end
            OP_SLL:  begin c.is_shift = 1'b1; c.sh_kind = SH_LEFT; end
            OP_SRL:  begin c.is_shift = 1'b1; c.sh_kind = SH_RLOG; end
            OP_SRA:  begin c.is_shift = 1'b1; c.sh_kind = SH_RARI; end
            OP_SLLV: begin c.is_shift = 1'b1; c.shift_var = 1'b1; c.sh_kind = SH_LEFT; end
            OP_SRLV: begin c.is_shift = 1'b1; c.shift_var = 1'b1; c.sh_kind = SH_RLOG; end
            OP_SRAV: begin c.is_shift = 1'b1; c.shift_var = 1'b1; c.sh_kind = SH_RARI; end
            OP_LUI:  begin c.is_lui = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rialu_operand_sel.sv
// Second-operand selector: picks the register operand or the widened
// immediate. Assumes XLEN > IMM_W. Extension is chosen by sext_i.
module rialu_operand_sel #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             sext_i,
    output logic [XLEN-1:0]  b_o
);
    localparam int EXT_W = XLEN - IMM_W;

    logic             fill_bit;
    logic [XLEN-1:0]  imm_wide;

    // Extension bit is the immediate's top bit only in sign mode
    assign fill_bit = sext_i & imm_i[IMM_W-1];

    // Widen the immediate to the datapath width
    assign imm_wide = {{EXT_W{fill_bit}}, imm_i};

    // Choose register operand or widened immediate
    always_comb begin
        b_o = use_imm_i ? imm_wide : b_i;
    end
endmodule

// File: rtl/rialu_addsub.sv
// Shared adder/subtractor. Subtraction inverts the second operand and
// injects a carry. Overflow is raised only when chk_ovf_i is set.
module rialu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         chk_ovf_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    logic [W-1:0] b_x;
    logic [W-1:0] cin_w;
    logic         same_in_sign;
    logic         sign_flip;

    // Conditionally invert the second operand for subtraction
    assign b_x   = b_i ^ {W{sub_i}};
    assign cin_w = {{(W-1){1'b0}}, sub_i};

    // Single carry chain for both directions, wrapping modulo 2^W
    always_comb begin
        sum_o = a_i + b_x + cin_w;
    end

    // Overflow: equal signs into the adder but a different sign out
    assign same_in_sign = (a_i[W-1] == b_x[W-1]);
    assign sign_flip    = (sum_o[W-1] != a_i[W-1]);

    // Report overflow only for the trapping forms
    always_comb begin
        ovf_o = chk_ovf_i & same_in_sign & sign_flip;
    end
endmodule

// File: rtl/rialu_shifter.sv
// Logarithmic barrel shifter. Right shifts are built directly; left
// shifts reverse the bits around the right shifter. Assumes W = 2**SHW.
module rialu_shifter #(
    parameter int W   = 32,
    parameter int SHW = 5
) (
    input  logic [W-1:0]           data_i,
    input  logic [SHW-1:0]         amt_i,
    input  rialu_pkg::shift_kind_e kind_i,
    output logic [W-1:0]           data_o
);
    logic             go_left;
    logic             fill;
    logic [W-1:0]     rev_in;
    logic [W-1:0]     rev_out;
    logic [W-1:0]     stage [0:SHW];

    // Direction and fill bit for the right-shift core
    assign go_left = (kind_i == rialu_pkg::SH_LEFT);
    assign fill    = (kind_i == rialu_pkg::SH_RARI) & data_i[W-1];

    // Reverse input bits so a left shift becomes a right shift
    always_comb begin
        for (int i = 0; i < W; i++) begin
            rev_in[i] = data_i[W-1-i];
        end
    end

    assign stage[0] = go_left ? rev_in : data_i;

    // One stage per amount bit, each moving by a power of two
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt_i[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
    end

    // Reverse back the result of a left shift
    always_comb begin
        for (int i = 0; i < W; i++) begin
            rev_out[i] = stage[SHW][W-1-i];
        end
    end

    // Select final orientation
    always_comb begin
        data_o = go_left ? rev_out : stage[SHW];
    end
endmodule

// File: rtl/rialu_logic.sv
// Bitwise unit: AND, OR, XOR, NOR selected by a 2-bit function code.
module rialu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0]         a_i,
    input  logic [W-1:0]         b_i,
    input  rialu_pkg::logic_fn_e fn_i,
    output logic [W-1:0]         y_o
);
    // Evaluate the selected bitwise function
    always_comb begin
        case (fn_i)
            rialu_pkg::LF_AND: y_o = a_i & b_i;
            rialu_pkg::LF_OR:  y_o = a_i | b_i;
            rialu_pkg::LF_XOR: y_o = a_i ^ b_i;
            default:           y_o = ~(a_i | b_i);
        endcase
    end
endmodule

// File: rtl/risc_int_alu.sv
// Integer execution unit: combinational. Decodes the operation code,
// selects the second operand, runs the adder, bitwise unit and shifter
// in parallel and muxes one result. Overflow is reported, never acted on.
// Assumes XLEN is a power of two and larger than IMM_W.
module risc_int_alu #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int SHW   = $clog2(XLEN)
) (
    input  logic [3:0]       op_i,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             sext_i,
    input  logic [SHW-1:0]   shamt_i,
    output logic [XLEN-1:0]  result_o,
    output logic             ovf_o
);
    import rialu_pkg::*;

    localparam int LOW_W = XLEN - IMM_W;

    alu_ctrl_t        ctrl;
    logic [XLEN-1:0]  b_eff;
    logic [XLEN-1:0]  sum;
    logic             add_ovf;
    logic [SHW-1:0]   sh_amt;
    logic [XLEN-1:0]  sh_res;
    logic [XLEN-1:0]  log_res;
    logic [XLEN-1:0]  lui_res;

    // Decode operation into control fields
    always_comb begin
        ctrl = decode_op(op_i);
    end

    rialu_operand_sel #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) u_opsel (
        .b_i       (b_i),
        .imm_i     (imm_i),
        .use_imm_i (use_imm_i),
        .sext_i    (sext_i),
        .b_o       (b_eff)
    );

    rialu_addsub #(
        .W (XLEN)
    ) u_addsub (
        .a_i       (a_i),
        .b_i       (b_eff),
        .sub_i     (ctrl.is_sub),
        .chk_ovf_i (ctrl.is_arith & ctrl.is_signed),
        .sum_o     (sum),
        .ovf_o     (add_ovf)
    );

    rialu_logic #(
        .W (XLEN)
    ) u_logic (
        .a_i  (a_i),
        .b_i  (b_eff),
        .fn_i (ctrl.log_fn),
        .y_o  (log_res)
    );

    // Shift distance from the constant field or the second operand's low bits
    always_comb begin
        sh_amt = ctrl.shift_var ? b_eff[SHW-1:0] : shamt_i;
    end

    rialu_shifter #(
        .W   (XLEN),
        .SHW (SHW)
    ) u_shift (
        .data_i (a_i),
        .amt_i  (sh_amt),
        .kind_i (ctrl.sh_kind),
        .data_o (sh_res)
    );

    // Place the immediate in the upper part of the word
    assign lui_res = {imm_i, {LOW_W{1'b0}}};

    // Select the result of the active operation class
    always_comb begin
        if (ctrl.is_arith) begin
            result_o = sum;
        end else if (ctrl.is_logic) begin
            result_o = log_res;
        end else if (ctrl.is_shift) begin
            result_o = sh_res;
        end else if (ctrl.is_lui) begin
            result_o = lui_res;
        end else begin
            result_o = '0;
        end
    end

    // Overflow comes only from the adder's trapping path
    always_comb begin
        ovf_o = add_ovf;
    end
endmodule

// File: rtl/risc_int_alu_chk.sv
// Checker for the integer execution unit: immediate assertions evaluated
// whenever the ports change. The unit has no clock, so no clocked properties.
module risc_int_alu_chk #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int SHW   = 5
) (
    input logic [3:0]       op_i,
    input logic [XLEN-1:0]  a_i,
    input logic [XLEN-1:0]  b_i,
    input logic [IMM_W-1:0] imm_i,
    input logic             use_imm_i,
    input logic             sext_i,
    input logic [SHW-1:0]   shamt_i,
    input logic [XLEN-1:0]  result_o,
    input logic             ovf_o
);
    import rialu_pkg::*;

    logic unused_ok;
    assign unused_ok = ^{b_i, use_imm_i, sext_i};

    // Port-level invariants per operation class
    always_comb begin
        p_ovf_trap_only_r2: assert (!ovf_o || op_i == OP_ADD || op_i == OP_SUB)
            else $error("overflow on non-trapping code %0d", op_i);
        p_ovf_sign_flip_r2: assert (!ovf_o || (result_o[XLEN-1] != a_i[XLEN-1]))
            else $error("overflow without sign flip");
        p_no_overflow_r3: assert (!((op_i == OP_ADDU || op_i == OP_SUBU) && ovf_o))
            else $error("unsigned form flagged overflow");
        p_and_subset_r4: assert (op_i != OP_AND || (result_o & ~a_i) == '0)
            else $error("AND result has bits outside first operand");
        p_srl_zero_fill_r5: assert (!(op_i == OP_SRL && shamt_i != '0) || !result_o[XLEN-1])
            else $error("logical right shift filled with one");
        p_sra_sign_fill_r5: assert (op_i != OP_SRA || result_o[XLEN-1] == a_i[XLEN-1])
            else $error("arithmetic right shift lost sign");
        p_lui_place_r8: assert (op_i != OP_LUI ||
                               (result_o[XLEN-1 -: IMM_W] == imm_i &&
                                result_o[XLEN-IMM_W-1:0] == '0 && !ovf_o))
            else $error("LUI placement wrong");
        p_rsvd_zero_r10: assert (op_i != OP_RSVD || (result_o == '0 && !ovf_o))
            else $error("reserved code produced output");
    end
endmodule

bind risc_int_alu risc_int_alu_chk #(
    .XLEN  (XLEN),
    .IMM_W (IMM_W),
    .SHW   (SHW)
) u_chk (
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .sext_i    (sext_i),
    .shamt_i   (shamt_i),
    .result_o  (result_o),
    .ovf_o     (ovf_o)
);

// File: tb/risc_int_alu_tb.sv
module risc_int_alu_tb;
    logic        clk = 1'b0;
    logic [3:0]  op;
    logic [31:0] a, b;
    logic [15:0] imm;
    logic        use_imm, sext;
    logic [4:0]  shamt;
    logic [31:0] res;
    logic        ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    risc_int_alu u_dut (
        .op_i(op), .a_i(a), .b_i(b), .imm_i(imm), .use_imm_i(use_imm),
        .sext_i(sext), .shamt_i(shamt), .result_o(res), .ovf_o(ovf)
    );

    function automatic logic [31:0] second_op(logic [31:0] bv, logic [15:0] iv, logic u, logic s);
        if (!u) return bv;
        if (s) return {{16{iv[15]}}, iv};
        return {16'h0, iv};
    endfunction

    function automatic logic [31:0] ref_res(logic [3:0] o, logic [31:0] av, logic [31:0] bv,
                                            logic [15:0] iv, logic u, logic s, logic [4:0] sh);
        logic [31:0] y;
        y = second_op(bv, iv, u, s);
        case (o)
            4'd0, 4'd1: return av + y;
            4'd2, 4'd3: return av - y;
            4'd4: return av & y;
            4'd5: return av | y;
            4'd6: return av ^ y;
            4'd7: return ~(av | y);
            4'd8: return av << sh;
            4'd9: return av >> sh;
            4'd10: return $unsigned($signed(av) >>> sh);
            4'd11: return av << y[4:0];
            4'd12: return av >> y[4:0];
            4'd13: return $unsigned($signed(av) >>> y[4:0]);
            4'd14: return {iv, 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic ref_ovf(logic [3:0] o, logic [31:0] av, logic [31:0] bv,
                                     logic [15:0] iv, logic u, logic s);
        longint sa, sb, t;
        sa = longint'($signed(av));
        sb = longint'($signed(second_op(bv, iv, u, s)));
        if (o == 4'd0) t = sa + sb;
        else if (o == 4'd2) t = sa - sb;
        else return 1'b0;
        return (t > 64'sd2147483647) || (t < -64'sd2147483648);
    endfunction

    function automatic string res_tag(logic [3:0] o, logic u);
        if (o <= 4'd7 && u) return "R7";
        if (o <= 4'd3) return "R1";
        if (o <= 4'd7) return "R4";
        if (o <= 4'd10) return "R5";
        if (o <= 4'd13) return "R6";
        if (o == 4'd14) return "R8";
        return "R10";
    endfunction

    function automatic string ovf_tag(logic [3:0] o);
        if (o == 4'd0 || o == 4'd2) return "R2";
        if (o <= 4'd3) return "R3";
        if (o <= 4'd7) return "R4";
        if (o <= 4'd13) return "R5";
        if (o == 4'd14) return "R8";
        return "R10";
    endfunction

    task automatic drive(logic [3:0] o, logic [31:0] av, logic [31:0] bv, logic [15:0] iv,
                         logic u, logic s, logic [4:0] sh);
        @(negedge clk);
        op = o; a = av; b = bv; imm = iv; use_imm = u; sext = s; shamt = sh;
        #1;
    endtask

    task automatic check_now(string tag_r, string tag_o);
        logic [31:0] er;
        logic        eo;
        er = ref_res(op, a, b, imm, use_imm, sext, shamt);
        eo = ref_ovf(op, a, b, imm, use_imm, sext);
        n_chk++;
        if (res !== er) begin
            n_bad++;
            $display("FAIL %s result op=%0d actual=%h expected=%h", tag_r, op, res, er);
        end
        n_chk++;
        if (ovf !== eo) begin
            n_bad++;
            $display("FAIL %s overflow op=%0d actual=%0b expected=%0b", tag_o, op, ovf, eo);
        end
    endtask

    task automatic run(logic [3:0] o, logic [31:0] av, logic [31:0] bv, logic [15:0] iv,
                       logic u, logic s, logic [4:0] sh);
        drive(o, av, bv, iv, u, s, sh);
        check_now(res_tag(o, u), ovf_tag(o));
    endtask

    task automatic expect_val(string tag, logic [31:0] er, logic eo);
        n_chk++;
        if (res !== er || ovf !== eo) begin
            n_bad++;
            $display("FAIL %s actual=%h/%0b expected=%h/%0b", tag, res, ovf, er, eo);
        end
    endtask

    initial begin
        op = 4'd0; a = '0; b = '0; imm = '0; use_imm = 1'b0; sext = 1'b0; shamt = '0;
        void'($urandom(32'h5EED_0042));
        repeat (2) @(posedge clk);
        drive(4'd0, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, 5'd0);
        expect_val("R1 idle", 32'h0, 1'b0);

        // R2 / R9: signed overflow corners with wrapped results
        drive(4'd0, 32'h7fffffff, 32'h1, 16'h0, 1'b0, 1'b0, 5'd0);
        expect_val("R9 add wrap", 32'h80000000, 1'b1);
        drive(4'd0, 32'h80000000, 32'h80000000, 16'h0, 1'b0, 1'b0, 5'd0);
        expect_val("R2 add neg", 32'h0, 1'b1);
        drive(4'd2, 32'h80000000, 32'h1, 16'h0, 1'b0, 1'b0, 5'd0);
        expect_val("R9 sub wrap", 32'h7fffffff, 1'b1);
        drive(4'd2, 32'h0, 32'h80000000, 16'h0, 1'b0, 1'b0, 5'd0);
        expect_val("R2 sub minint", 32'h80000000, 1'b1);
        drive(4'd2, 32'hffffffff, 32'h7fffffff, 16'h0, 1'b0, 1'b0, 5'd0);
        expect_val("R2 sub no ovf", 32'h80000000, 1'b0);
        // R3: unsigned forms never flag
        drive(4'd1, 32'h7fffffff, 32'h1, 16'h0, 1'b0, 1'b0, 5'd0);
        expect_val("R3 addu", 32'h80000000, 1'b0);
        drive(4'd3, 32'h80000000, 32'h1, 16'h0, 1'b0, 1'b0, 5'd0);
        expect_val("R3 subu", 32'h7fffffff, 1'b0);
        // R7: immediate extension, b_i ignored
        drive(4'd0, 32'h7fffffff, 32'hdeadbeef, 16'h0001, 1'b1, 1'b1, 5'd0);
        expect_val("R7 addi ovf", 32'h80000000, 1'b1);
        drive(4'd1, 32'h10, 32'h12345678, 16'hfff0, 1'b1, 1'b1, 5'd0);
        expect_val("R7 sext", 32'h0, 1'b0);
        drive(4'd5, 32'h0, 32'hffffffff, 16'h8000, 1'b1, 1'b0, 5'd0);
        expect_val("R7 zext", 32'h00008000, 1'b0);
        // R5: shift fill rules
        drive(4'd10, 32'h80000000, 32'h0, 16'h0, 1'b0, 1'b0, 5'd31);
        expect_val("R5 sra", 32'hffffffff, 1'b0);
        drive(4'd9, 32'h80000000, 32'h0, 16'h0, 1'b0, 1'b0, 5'd31);
        expect_val("R5 srl", 32'h1, 1'b0);
        drive(4'd8, 32'h80000001, 32'h0, 16'h0, 1'b0, 1'b0, 5'd1);
        expect_val("R5 sll", 32'h2, 1'b0);
        // R6: register distance masked to 5 bits, shamt ignored
        drive(4'd12, 32'hf0000000, 32'hffffffe4, 16'h0, 1'b0, 1'b0, 5'd1);
        expect_val("R6 srlv", 32'h0f000000, 1'b0);
        drive(4'd13, 32'h80000000, 32'h00000104, 16'h0, 1'b0, 1'b0, 5'd0);
        expect_val("R6 srav", 32'hf8000000, 1'b0);
        // R8: LUI ignores operands
        drive(4'd14, 32'hffffffff, 32'hffffffff, 16'habcd, 1'b0, 1'b1, 5'd3);
        expect_val("R8 lui", 32'habcd0000, 1'b0);
        // R10: reserved code
        drive(4'd15, 32'h7fffffff, 32'h7fffffff, 16'hffff, 1'b1, 1'b1, 5'd7);
        expect_val("R10 rsvd", 32'h0, 1'b0);

        // Constrained random: biased operand values mixed with fully random ones
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ra, rb;
            int sel;
            sel = $urandom_range(0, 3);
            ra = $urandom();
            rb = $urandom();
            if (sel == 0) begin ra = {ra[31], {31{ra[30]}}}; rb = {rb[31], {31{rb[30]}}}; end
            if (sel == 1) ra = ra ^ 32'h7fffffff & {32{ra[0]}};
            run(4'($urandom_range(0, 15)), ra, rb, 16'($urandom()),
                1'($urandom()), 1'($urandom()), 5'($urandom()));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule